// File: doc/BRIEF.md
# Reliable Packet Receiver with Acknowledgement

This block sits behind a byte deframer on the receive side of a reliable serial link. It takes one deframed packet at a time as a byte stream, with a marker on the final byte. It validates the four-byte header and its checksum, then sorts the packet into a data packet or a pure acknowledgement. Data packets are checked against a 3-bit expected sequence number.

Payload bytes of an in-order data packet go to the upper layer as soon as they arrive. At the end of the packet the block either confirms the stream with a commit strobe or cancels it with an abort strobe. An abort follows a failed integrity check, or a byte count that does not match the header. For every valid data packet the block asks the local transmitter to send an acknowledgement. The acknowledgement carries the sequence number expected next. Duplicates caused by a lost acknowledgement are acknowledged again, but their payload is not delivered a second time. The acknowledgement number found in each valid packet is handed to the transmitter so that it can retire frames it has already sent.

Top module: `relPktRx`

## Requirements
- R1: Header layout. Byte 0 holds SEQ in bits 2:0, ACK in bits 5:3, DIP in bit 6 and RP in bit 7. Byte 1 holds TYPE in bits 3:0 and LEN bits 3:0 in bits 7:4. Byte 2 holds LEN bits 11:4. Byte 3 is a checksum. The four bytes must add to 0 modulo 256. A packet that fails this check produces no activity on any output.
- R2: In an accepted-order data packet (TYPE 0xE), the bytes at positions 4 to 4+LEN-1 appear on `outValid`/`outData` one cycle after each arrives. Header and CRC bytes are never forwarded.
- R3: A data packet whose SEQ equals the expected value, and which passes every check, raises `outCommit` for one cycle, one cycle after its last byte. `outCommit` and `outAbort` are never high together.
- R4: Every valid data packet raises `ackReq` for one cycle, one cycle after its last byte. `ackNum` then holds the next expected SEQ.
- R5: A valid data packet whose SEQ differs from the expected value forwards no byte and produces no commit. It is still acknowledged, with the expected SEQ left unchanged.
- R6: The expected SEQ is 0 after reset and advances by one, modulo 8, on each commit.
- R7: When DIP=1, the last two bytes hold a CRC-16 sent high byte first. The CRC uses polynomial 0x1021, initial value 0xFFFF, MSB-first processing and no final XOR, taken over the header and payload. On a mismatch the packet gives no acknowledgement and no commit, and the SEQ does not advance. If bytes were already forwarded, `outAbort` is raised instead.
- R8: The received byte count must equal 4+LEN+2·DIP. A longer or shorter packet is handled like a CRC mismatch. A packet shorter than 4 bytes produces no activity.
- R9: A packet with TYPE 0x0, SEQ=0, DIP=0, RP=0 and LEN=0 is an acknowledgement. It raises `peerAckValid` with its ACK field on `peerAck`, and it raises neither `ackReq` nor any payload output. Any other TYPE, or TYPE 0x0 with a nonzero field, is dropped silently.
- R10: Every valid data packet, in order or not, also reports its ACK field on `peerAck` with `peerAckValid`.
- R11: A header whose implied total 4+LEN+2·DIP exceeds 384 bytes is dropped silently. A total of exactly 384 is accepted.
- R12: During and after reset, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Deframed byte present |
| inData | input | 8 | Deframed byte |
| inLast | input | 1 | Byte is the last of its packet |
| outValid | output | 1 | Payload byte strobe |
| outData | output | 8 | Payload byte |
| outCommit | output | 1 | Forwarded packet accepted |
| outAbort | output | 1 | Forwarded bytes must be discarded |
| ackReq | output | 1 | Request to send an acknowledgement |
| ackNum | output | 3 | Next expected sequence number |
| peerAckValid | output | 1 | Received ACK number valid |
| peerAck | output | 3 | ACK number from the remote side |

## Verification
Every output is one register stage from the input byte that causes it. A forwarded payload byte shows up one cycle after it is driven. Commit, abort, the acknowledgement request and the peer acknowledgement all show up one cycle after the byte marked last. The bench drives each byte on the falling edge and reads the outputs one nanosecond after the next rising edge. As a result, each observation belongs to exactly the byte just presented, and the bench accumulates them across the packet before comparing with its own sequence model.

// File: rtl/relRxPkg.sv
package relRxPkg;
  localparam int LEN_W = 12;
  localparam logic [3:0] TYPE_DATA = 4'hE;
  localparam logic [3:0] TYPE_ACK  = 4'h0;

  typedef struct packed {
    logic             rp;
    logic             dip;
    logic [2:0]       ack;
    logic [2:0]       seq;
    logic [3:0]       typ;
    logic [LEN_W-1:0] len;
  } hdrT;

  typedef struct packed {
    logic capHdr;
    logic crcEn;
    logic capCrcHi;
    logic fwdByte;
    logic advSeq;
  } ctlT;
endpackage

// File: rtl/relRxDatapath.sv
module relRxDatapath
  import relRxPkg::*;
#(
  parameter int MAX_PKT = 384,
  localparam int CNT_W = $clog2(MAX_PKT + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inLast,
  input  ctlT              ctl,
  output logic [CNT_W-1:0] idx,
  output hdrT              hdr,
  output logic             sumOk,
  output logic             crcMatch,
  output logic [2:0]       expSeq,
  output logic [7:0]       dataOut
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_PKT + 1);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       hb [3];
  logic [7:0]       sumReg;
  logic [7:0]       sumNext;
  logic [15:0]      crcReg;
  logic [7:0]       crcHi;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++)
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  assign idx = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (inValid) begin
      if (inLast) cnt <= '0;
      else if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hb[0] <= '0; hb[1] <= '0; hb[2] <= '0;
      sumReg <= '0;
    end else if (ctl.capHdr) begin
      if (cnt < CNT_W'(3)) hb[cnt[1:0]] <= inData;
      sumReg <= sumNext;
    end
  end

  assign sumNext = ((cnt == '0) ? 8'd0 : sumReg) + inData;
  assign sumOk   = (cnt == CNT_W'(3)) ? (sumNext == 8'd0) : (sumReg == 8'd0);

  assign hdr.seq = hb[0][2:0];
  assign hdr.ack = hb[0][5:3];
  assign hdr.dip = hb[0][6];
  assign hdr.rp  = hb[0][7];
  assign hdr.typ = hb[1][3:0];
  assign hdr.len = {hb[2], hb[1][7:4]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= 16'hFFFF;
      crcHi  <= '0;
    end else begin
      if (ctl.crcEn)
        crcReg <= crcStep((cnt == '0) ? 16'hFFFF : crcReg, inData);
      if (ctl.capCrcHi) crcHi <= inData;
    end
  end

  assign crcMatch = ({crcHi, inData} == crcReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expSeq  <= '0;
      dataOut <= '0;
    end else begin
      if (ctl.advSeq)  expSeq  <= expSeq + 3'd1;
      if (ctl.fwdByte) dataOut <= inData;
    end
  end
endmodule

// File: rtl/relRxControl.sv
module relRxControl
  import relRxPkg::*;
#(
  parameter int MAX_PKT = 384,
  localparam int CNT_W = $clog2(MAX_PKT + 2),
  localparam int TOT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [CNT_W-1:0] idx,
  input  hdrT              hdr,
  input  logic             sumOk,
  input  logic             crcMatch,
  input  logic [2:0]       expSeq,
  output ctlT              ctl,
  output logic             outValid,
  output logic             outCommit,
  output logic             outAbort,
  output logic             ackReq,
  output logic [2:0]       ackNum,
  output logic             peerAckValid,
  output logic [2:0]       peerAck
);
  logic [TOT_W-1:0] idxW, totalLen, payEnd;
  logic hdrKnown, typeOk, hdrOk, isData, inOrder;
  logic endNow, lenOk, crcOk, good, accept, abortNow, sentAny;

  assign idxW     = TOT_W'(idx);
  assign payEnd   = TOT_W'(4) + TOT_W'(hdr.len);
  assign totalLen = payEnd + (hdr.dip ? TOT_W'(2) : TOT_W'(0));
  assign hdrKnown = (idxW >= TOT_W'(3));
  assign isData   = (hdr.typ == TYPE_DATA);
  assign typeOk   = isData ||
                    ((hdr.typ == TYPE_ACK) && (hdr.seq == '0) && !hdr.dip &&
                     !hdr.rp && (hdr.len == '0));
  assign hdrOk    = hdrKnown && sumOk && typeOk && (totalLen <= TOT_W'(MAX_PKT));
  assign inOrder  = (hdr.seq == expSeq);

  assign ctl.capHdr   = inValid && (idxW < TOT_W'(4));
  assign ctl.crcEn    = inValid && ((idxW < TOT_W'(4)) || (idxW < payEnd));
  assign ctl.capCrcHi = inValid && (idxW >= TOT_W'(4)) && (idxW == payEnd);
  assign ctl.fwdByte  = inValid && (idxW >= TOT_W'(4)) && (idxW < payEnd) &&
                        hdrOk && isData && inOrder;

  assign endNow   = inValid && inLast;
  assign lenOk    = hdrOk && ((idxW + TOT_W'(1)) == totalLen);
  assign crcOk    = !hdr.dip || crcMatch;
  assign good     = endNow && lenOk && crcOk;
  assign accept   = good && isData && inOrder;
  assign abortNow = endNow && (sentAny || ctl.fwdByte) && !accept;
  assign ctl.advSeq = accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentAny      <= 1'b0;
      outValid     <= 1'b0;
      outCommit    <= 1'b0;
      outAbort     <= 1'b0;
      ackReq       <= 1'b0;
      ackNum       <= '0;
      peerAckValid <= 1'b0;
      peerAck      <= '0;
    end else begin
      if (endNow) sentAny <= 1'b0;
      else if (ctl.fwdByte) sentAny <= 1'b1;
      outValid     <= ctl.fwdByte;
      outCommit    <= accept;
      outAbort     <= abortNow;
      ackReq       <= good && isData;
      peerAckValid <= good;
      if (good && isData) ackNum <= accept ? expSeq + 3'd1 : expSeq;
      if (good) peerAck <= hdr.ack;
    end
  end
endmodule

// File: rtl/relPktRx.sv
module relPktRx
  import relRxPkg::*;
#(
  parameter int MAX_PKT = 384,
  localparam int CNT_W = $clog2(MAX_PKT + 2)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inLast,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outCommit,
  output logic       outAbort,
  output logic       ackReq,
  output logic [2:0] ackNum,
  output logic       peerAckValid,
  output logic [2:0] peerAck
);
  ctlT              ctl;
  hdrT              hdr;
  logic [CNT_W-1:0] idx;
  logic             sumOk, crcMatch;
  logic [2:0]       expSeq;

  relRxDatapath #(.MAX_PKT(MAX_PKT)) dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .ctl(ctl), .idx(idx), .hdr(hdr), .sumOk(sumOk), .crcMatch(crcMatch),
    .expSeq(expSeq), .dataOut(outData)
  );

  relRxControl #(.MAX_PKT(MAX_PKT)) cu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .idx(idx),
    .hdr(hdr), .sumOk(sumOk), .crcMatch(crcMatch), .expSeq(expSeq), .ctl(ctl),
    .outValid(outValid), .outCommit(outCommit), .outAbort(outAbort),
    .ackReq(ackReq), .ackNum(ackNum), .peerAckValid(peerAckValid), .peerAck(peerAck)
  );
endmodule

// File: rtl/relRxChecker.sv
module relRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       outValid,
  input logic       outCommit,
  input logic       outAbort,
  input logic       ackReq,
  input logic [2:0] ackNum,
  input logic       peerAckValid
);
  logic [2:0] chkSeq;
  logic       seenData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkSeq   <= '0;
      seenData <= 1'b0;
    end else begin
      if (outCommit) chkSeq <= chkSeq + 3'd1;
      seenData <= (outCommit || outAbort) ? 1'b0 : (seenData || outValid);
    end
  end

  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({outCommit, outAbort}));
  a_r4_commit_acked: assert property (@(posedge clk) disable iff (!rstN)
    outCommit |-> ackReq);
  a_r6_ack_advances: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && outCommit) |-> (ackNum == chkSeq + 3'd1));
  a_r5_dup_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !outCommit) |-> (ackNum == chkSeq));
  a_r8_abort_after_data: assert property (@(posedge clk) disable iff (!rstN)
    outAbort |-> (seenData || outValid));
  a_r10_ack_reports_peer: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> peerAckValid);
endmodule

bind relPktRx relRxChecker chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outCommit(outCommit),
  .outAbort(outAbort), .ackReq(ackReq), .ackNum(ackNum), .peerAckValid(peerAckValid)
);

// File: tb/relPktRx_test.sv
module relPktRx_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic outValid, outCommit, outAbort, ackReq, peerAckValid;
  logic [7:0] outData;
  logic [2:0] ackNum, peerAck;

  always #2 clk = ~clk;

  relPktRx uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outData(outData), .outCommit(outCommit), .outAbort(outAbort),
    .ackReq(ackReq), .ackNum(ackNum), .peerAckValid(peerAckValid), .peerAck(peerAck)
  );

  int vectors = 0, fails = 0, mSeq = 0, pktLen = 0;
  logic [7:0] pkt [0:511];
  logic [7:0] expPay [0:511];
  int gotN, gotCommit, gotAbort, gotAck, gotAckNum, gotPeer, gotPeerNum, dataBad;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic build(input int seq, input int ack, input int dip, input int rp,
                       input int typ, input int len, input int salt);
    logic [15:0] c;
    pkt[0] = 8'((rp << 7) | (dip << 6) | ((ack & 7) << 3) | (seq & 7));
    pkt[1] = 8'(((len & 15) << 4) | (typ & 15));
    pkt[2] = 8'(len >> 4);
    pkt[3] = 8'(-(int'(pkt[0]) + int'(pkt[1]) + int'(pkt[2])));
    for (int k = 0; k < len; k++) begin
      expPay[k] = 8'(k * 7 + salt * 13 + 5);
      pkt[4 + k] = expPay[k];
    end
    pktLen = 4 + len;
    if (dip != 0) begin
      c = 16'hFFFF;
      for (int k = 0; k < pktLen; k++) c = crcByte(c, pkt[k]);
      pkt[pktLen] = c[15:8];
      pkt[pktLen + 1] = c[7:0];
      pktLen += 2;
    end
  endtask

  task automatic send();
    gotN = 0; gotCommit = 0; gotAbort = 0; gotAck = 0; gotPeer = 0; dataBad = 0;
    gotAckNum = -1; gotPeerNum = -1;
    for (int i = 0; i < pktLen; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = pkt[i]; inLast = (i == pktLen - 1);
      @(posedge clk); #1;
      if (outValid) begin
        if (outData !== expPay[gotN]) dataBad++;
        gotN++;
      end
      if (outCommit) gotCommit++;
      if (outAbort) gotAbort++;
      if (ackReq) begin gotAck++; gotAckNum = int'(ackNum); end
      if (peerAckValid) begin gotPeer++; gotPeerNum = int'(peerAck); end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic verify(input string tag, input int eN, input int eCommit, input int eAbort,
                        input int eAck, input int eAckNum, input int ePeer, input int ePeerNum);
    check(gotN == eN, {tag, " data count"}, gotN, eN);
    check(dataBad == 0, {tag, " data value"}, dataBad, 0);
    check(gotCommit == eCommit, {tag, " commit"}, gotCommit, eCommit);
    check(gotAbort == eAbort, {tag, " abort"}, gotAbort, eAbort);
    check(gotAck == eAck, {tag, " ackReq"}, gotAck, eAck);
    if (eAck != 0) check(gotAckNum == eAckNum, {tag, " ackNum"}, gotAckNum, eAckNum);
    check(gotPeer == ePeer, {tag, " peerAckValid"}, gotPeer, ePeer);
    if (ePeer != 0) check(gotPeerNum == ePeerNum, {tag, " peerAck"}, gotPeerNum, ePeerNum);
  endtask

  task automatic sendGood(input string tag, input int dip, input int len, input int ack, input int salt);
    build(mSeq, ack, dip, 1, 14, len, salt);
    send();
    verify(tag, len, 1, 0, 1, (mSeq + 1) % 8, 1, ack);
    mSeq = (mSeq + 1) % 8;
  endtask

  task automatic expectSilent(input string tag);
    send();
    verify(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1;
    check({outValid, outCommit, outAbort, ackReq, peerAckValid} == 5'b0, "R12 in reset",
          int'({outValid, outCommit, outAbort, ackReq, peerAckValid}), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check({outValid, outCommit, outAbort, ackReq, peerAckValid} == 5'b0, "R12 after reset",
          int'({outValid, outCommit, outAbort, ackReq, peerAckValid}), 0);

    // R1 header example: bytes E8 3E 00 DA decode to seq 0, ack 5, DIP, RP, data, LEN 3
    build(0, 5, 1, 1, 14, 3, 0);
    check({pkt[0], pkt[1], pkt[2], pkt[3]} == 32'hE83E00DA, "R1 layout",
          int'({pkt[0], pkt[1], pkt[2], pkt[3]}), 32'hE83E00DA);
    pkt[4] = 8'h41; pkt[5] = 8'h42; pkt[6] = 8'hC0;
    expPay[0] = 8'h41; expPay[1] = 8'h42; expPay[2] = 8'hC0;
    begin
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < 7; k++) c = crcByte(c, pkt[k]);
      pkt[7] = c[15:8]; pkt[8] = c[7:0];
    end
    send();
    verify("R2 R3 R7 example", 3, 1, 0, 1, 1, 1, 5);
    mSeq = 1;

    // R6 sweep: in-order packets through two sequence wraps, mixed LEN and DIP
    for (int n = 0; n < 20; n++) sendGood("R6 R4 R2 sweep", n % 2, n % 11, n % 8, n);

    // R5 duplicate after lost ack, and a far-off SEQ
    build((mSeq + 7) % 8, 2, 1, 1, 14, 4, 40); send();
    verify("R5 duplicate", 0, 0, 0, 1, mSeq, 1, 2);
    build((mSeq + 3) % 8, 6, 0, 1, 14, 2, 41); send();
    verify("R5 out of order", 0, 0, 0, 1, mSeq, 1, 6);

    // R1 bad checksum, then the same packet repaired is still in order
    build(mSeq, 1, 1, 1, 14, 5, 42); pkt[3] ^= 8'h01;
    expectSilent("R1 bad checksum");
    sendGood("R1 repaired", 1, 5, 1, 42);

    // R7 CRC mismatch aborts forwarded bytes and leaves SEQ
    build(mSeq, 3, 1, 1, 14, 5, 43); pkt[pktLen - 1] ^= 8'h80; send();
    verify("R7 bad crc", 5, 0, 1, 0, 0, 0, 0);
    sendGood("R7 retry", 1, 5, 3, 43);

    // R8 length mismatches
    build(mSeq, 4, 0, 1, 14, 4, 44); pkt[pktLen] = 8'h99; pktLen++; send();
    verify("R8 long", 4, 0, 1, 0, 0, 0, 0);
    build(mSeq, 4, 0, 1, 14, 6, 45); pktLen = 7; send();
    verify("R8 short", 3, 0, 1, 0, 0, 0, 0);
    build(mSeq, 4, 0, 1, 14, 6, 45); pktLen = 2;
    expectSilent("R8 truncated header");
    sendGood("R8 recovered", 0, 6, 4, 45);

    // R9 acknowledgement packets and bad types
    build(0, 3, 0, 0, 0, 0, 0); send();
    verify("R9 ack packet", 0, 0, 0, 0, 0, 1, 3);
    build(0, 3, 0, 0, 0, 1, 0);
    expectSilent("R9 ack with length");
    build(1, 3, 0, 0, 0, 0, 0);
    expectSilent("R9 ack with seq");
    build(mSeq, 3, 0, 1, 5, 2, 46);
    expectSilent("R9 unknown type");

    // R11 size limit
    build(mSeq, 7, 1, 1, 14, 379, 47);
    expectSilent("R11 oversize");
    sendGood("R11 max with crc", 1, 378, 7, 48);
    sendGood("R11 max no crc", 0, 380, 0, 49);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule